// File: doc/BRIEF.md
# Replicated Register Bank with Steering

This block holds a set of control registers of which each exists once per hardware unit, with all copies of one register reachable through a single bus offset. Units are numbered by a group ID and an instance ID within the group. A steering selector register decides which copy a bus access reaches. It holds a group field, an instance field and a multicast flag. A write with the flag set fans out to every copy. A write with the flag clear lands in the steered copy only. A read always returns one copy, the steered one, whatever the flag says.

An availability input carries one bit per unit, where a zero marks a unit that is fused off or power gated. Any access steered to an absent unit is terminated: a read gives zero and a unicast write is dropped. A multicast write skips absent units, which keep their old contents. The bus is a plain single-cycle register port. Every cycle carries one access, there is no back-pressure, and read data is registered, so a read returns one clock after its address is presented.

Top module: `repl_steer_bank`

## Requirements
- R1: After reset the selector reads as multicast with group 0 and instance 0 (value 0x8000 with default field positions), and every copy of every replicated register holds zero.
- R2: A write to a replicated offset with the multicast flag set loads the write data into that register's copy in every present unit. Copies in absent units keep their value.
- R3: A write to a replicated offset with the multicast flag clear changes only the copy at flat index group*INSTS+instance. All other copies keep their values.
- R4: A unicast write steered to an absent unit changes no copy. The old value is seen again once the unit becomes present.
- R5: A read of a replicated offset returns the steered copy, with the same result whether the multicast flag is set or clear.
- R6: A read steered to an absent unit, or to a group or instance outside the configured counts, returns zero.
- R7: The selector sits at offset 0. The multicast flag is bit 15, the group ID starts at bit 8 and the instance ID starts at bit 0 (field positions are parameters). Other bits read as zero. A selector write governs the very next access.
- R8: Read data appears on the clock edge after the address is presented. Offsets that map to neither the selector nor a replicated register read as zero.
- R9: Replicated registers sit at offsets 1 to NUM_REGS. A write to one offset leaves the copies of every other offset unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset of the current access |
| bus_we | input | 1 | High for a write, low for a read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data of the previous cycle's address |
| unit_avail | input | GROUPS*INSTS | Per-unit presence, bit group*INSTS+instance; zero means fused off or gated |

## Verification
Read data is due exactly one rising edge after the address is held. Write effects, including selector writes, are visible to the next access. The bench drives every access on a falling edge and samples bus_rdata one time unit after the following rising edge. The bench sweeps all sixteen availability masks of a two-group, two-instance configuration. Under each mask it applies multicast and unicast writes to every steering target and then reads every copy, both under the mask and with all units present. It predicts each value from a per-copy model.

// File: rtl/repl_steer_pkg.sv
package repl_steer_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SEL  = 2'd1,
    ACC_REG  = 2'd2
  } acc_e;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/repl_steer_sel.sv
module repl_steer_sel #(
  parameter int DATA_W   = 16,
  parameter int GW       = 1,
  parameter int IW       = 1,
  parameter int GRP_LSB  = 8,
  parameter int INST_LSB = 0,
  parameter int MC_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              d_mc,
  input  logic [GW-1:0]     d_grp,
  input  logic [IW-1:0]     d_inst,
  output logic              mc,
  output logic [GW-1:0]     grp,
  output logic [IW-1:0]     inst,
  output logic [DATA_W-1:0] view
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc   <= 1'b1;
      grp  <= '0;
      inst <= '0;
    end else if (wr) begin
      mc   <= d_mc;
      grp  <= d_grp;
      inst <= d_inst;
    end
  end

  always_comb begin
    view                  = '0;
    view[MC_BIT]          = mc;
    view[GRP_LSB +: GW]   = grp;
    view[INST_LSB +: IW]  = inst;
  end

  // R7: a selector write is held from the next cycle on
  assert_sel_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mc == $past(d_mc)) && (grp == $past(d_grp)) && (inst == $past(d_inst)));

endmodule

// File: rtl/repl_steer_decode.sv
module repl_steer_decode #(
  parameter int GROUPS = 2,
  parameter int INSTS  = 2,
  parameter int GW     = 1,
  parameter int IW     = 1,
  parameter int NINST  = 4,
  parameter int IDXW   = 2
) (
  input  logic [GW-1:0]    grp,
  input  logic [IW-1:0]    inst,
  input  logic [NINST-1:0] avail,
  output logic [NINST-1:0] tgt_vec,
  output logic             present
);

  logic             in_range;
  logic [IDXW-1:0]  idx;
  logic [NINST-1:0] shifted;

  always_comb begin
    in_range = (int'(grp) < GROUPS) && (int'(inst) < INSTS);
    idx      = IDXW'(int'(grp) * INSTS + int'(inst));
    shifted  = avail >> idx;
    present  = in_range && shifted[0];
  end

  for (genvar k = 0; k < NINST; k++) begin : g_tgt
    assign tgt_vec[k] = present && (idx == IDXW'(k));
  end

endmodule

// File: rtl/repl_steer_cell.sv
module repl_steer_cell #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end

endmodule

// File: rtl/repl_steer_bank.sv
module repl_steer_bank
  import repl_steer_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int GROUPS   = 2,
  parameter int INSTS    = 2,
  parameter int NUM_REGS = 2,
  parameter int SEL_ADDR = 0,
  parameter int REG_BASE = 1,
  parameter int GRP_LSB  = 8,
  parameter int INST_LSB = 0,
  parameter int MC_BIT   = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [GROUPS*INSTS-1:0]   unit_avail
);

  localparam int GW    = width_of(GROUPS);
  localparam int IW    = width_of(INSTS);
  localparam int NINST = GROUPS * INSTS;
  localparam int IDXW  = width_of(NINST);
  localparam int NCELL = NUM_REGS * NINST;

  acc_e                 acc;
  logic [NUM_REGS-1:0]  reg_hit;
  logic                 sel_wr;
  logic                 reg_wr;
  logic                 sel_mc;
  logic [GW-1:0]        sel_grp;
  logic [IW-1:0]        sel_inst;
  logic [DATA_W-1:0]    sel_view;
  logic [NINST-1:0]     tgt_vec;
  logic                 present;
  logic [NCELL-1:0]     wr_flat;
  logic [DATA_W-1:0]    q [NUM_REGS][NINST];
  logic [DATA_W-1:0]    rd_val;

  // Address decode
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
    assign reg_hit[r] = (bus_addr == ADDR_W'(REG_BASE + r));
  end

  always_comb begin
    acc = ACC_NONE;
    if (bus_addr == ADDR_W'(SEL_ADDR)) acc = ACC_SEL;
    else if (|reg_hit)                 acc = ACC_REG;
  end

  assign sel_wr = bus_we && (acc == ACC_SEL);
  assign reg_wr = bus_we && (acc == ACC_REG);

  repl_steer_sel #(
    .DATA_W(DATA_W), .GW(GW), .IW(IW),
    .GRP_LSB(GRP_LSB), .INST_LSB(INST_LSB), .MC_BIT(MC_BIT)
  ) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (sel_wr),
    .d_mc   (bus_wdata[MC_BIT]),
    .d_grp  (bus_wdata[GRP_LSB +: GW]),
    .d_inst (bus_wdata[INST_LSB +: IW]),
    .mc     (sel_mc),
    .grp    (sel_grp),
    .inst   (sel_inst),
    .view   (sel_view)
  );

  repl_steer_decode #(
    .GROUPS(GROUPS), .INSTS(INSTS), .GW(GW), .IW(IW),
    .NINST(NINST), .IDXW(IDXW)
  ) u_dec (
    .grp     (sel_grp),
    .inst    (sel_inst),
    .avail   (unit_avail),
    .tgt_vec (tgt_vec),
    .present (present)
  );

  // Storage: one cell per (register, unit)
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar k = 0; k < NINST; k++) begin : g_unit
      assign wr_flat[r*NINST + k] =
        reg_wr && reg_hit[r] && (sel_mc ? unit_avail[k] : tgt_vec[k]);

      repl_steer_cell #(.DATA_W(DATA_W)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_flat[r*NINST + k]),
        .d     (bus_wdata),
        .q     (q[r][k])
      );

      // R4: an absent unit's copy never moves
      assert_absent_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_avail[k] |=> $stable(q[r][k]));

      // R2: multicast write reaches every present copy of the addressed register
      assert_mc_fanout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_mc && reg_hit[r] && unit_avail[k]) |=> (q[r][k] == $past(bus_wdata)));
    end
  end

  // Read mux: single steered copy, or the selector view
  always_comb begin
    rd_val = '0;
    if (acc == ACC_SEL) begin
      rd_val = sel_view;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        for (int k = 0; k < NINST; k++) begin
          if (reg_hit[r] && tgt_vec[k]) rd_val = rd_val | q[r][k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_val;
  end

  // R3: a unicast write touches at most one copy
  assert_unicast_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_mc |-> $onehot0(wr_flat));

  // R6: a terminated read returns zero on the next edge
  assert_term_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc == ACC_REG) && !present) |=> (bus_rdata == '0));

  // R8: unmapped offsets read zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/repl_steer_bank_bench.sv
module repl_steer_bank_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  unit_avail = 4'hF;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // bench model
  int          m_mc = 1, m_grp = 0, m_inst = 0;
  logic [15:0] m_q [2][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_steer_bank u_repl_steer_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .unit_avail (unit_avail)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    if (a == 4'd0) begin
      m_mc   = int'(d[15]);
      m_grp  = int'(d[8]);
      m_inst = int'(d[0]);
    end else if (a == 4'd1 || a == 4'd2) begin
      for (int k = 0; k < 4; k++) begin
        if (unit_avail[k] && (m_mc == 1 || k == m_grp*2 + m_inst))
          m_q[int'(a) - 1][k] = d;
      end
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  function automatic logic [15:0] expect_rd(input logic [3:0] a);
    int k;
    k = m_grp*2 + m_inst;
    if (a == 4'd0) return 16'((m_mc << 15) | (m_grp << 8) | m_inst);
    if (a == 4'd1 || a == 4'd2) return unit_avail[k] ? m_q[int'(a) - 1][k] : 16'h0000;
    return 16'h0000;
  endfunction

  task automatic rd_check(input logic [3:0] a, input string tag);
    logic [15:0] e;
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    e = expect_rd(a);
    @(posedge clk);
    #1;
    check(tag, bus_rdata, e);
  endtask

  task automatic steer(input int mc, input int g, input int i);
    bus_wr(4'd0, 16'((mc << 15) | (g << 8) | i));
  endtask

  initial begin
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 4; k++) m_q[r][k] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_check(4'd0, "R1 selector reset");
    rd_check(4'd1, "R1 reg1 reset");
    rd_check(4'd2, "R1 reg2 reset");
    // R8: unmapped offsets
    rd_check(4'd3, "R8 unmapped 3");
    rd_check(4'd15, "R8 unmapped 15");
    // R7: undefined selector bits read zero
    bus_wr(4'd0, 16'h7FFF);
    rd_check(4'd0, "R7 selector spare bits");

    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      unit_avail = 4'(m);
      steer(1, 0, 0);
      rd_check(4'd0, "R7 selector readback");
      bus_wr(4'd1, 16'hA000 | 16'(m));   // R2 multicast
      for (int mc = 0; mc < 2; mc++)
        for (int g = 0; g < 2; g++)
          for (int i = 0; i < 2; i++) begin
            steer(mc, g, i);
            if (unit_avail[g*2+i]) rd_check(4'd1, "R5 R2 steered read");
            else                   rd_check(4'd1, "R6 terminated read");
          end
      for (int g = 0; g < 2; g++)
        for (int i = 0; i < 2; i++) begin
          steer(0, g, i);
          bus_wr(4'd2, 16'h5000 | 16'(m << 4) | 16'(g*2 + i));  // R3 unicast
          rd_check(4'd0, "R7 selector before next access");
        end
      // expose every copy with all units present
      @(negedge clk);
      unit_avail = 4'hF;
      for (int g = 0; g < 2; g++)
        for (int i = 0; i < 2; i++) begin
          steer(1, g, i);
          rd_check(4'd1, "R2 R9 reg1 copy kept");
          rd_check(4'd2, "R3 R4 reg2 copy");
        end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule